// File: doc/BRIEF.md
# Motion Report Poll Sequencer

This block fetches one complete motion report from an optical navigation sensor. It does so through a serial register master that is not part of this block. A one-cycle start pulse makes the sequencer issue three register reads back-to-back: the motion status register, then the horizontal displacement register, then the vertical displacement register. The three registers sit at consecutive addresses. The sequencer waits for each read to be acknowledged before it asks for the next one.

The two displacement bytes are signed two's complement counts. The block holds them in staging registers while the sequence runs. The status byte is reduced to a three-bit result and a resolution flag:

- motion in bit 0
- LED fault in bit 1
- overflow in bit 2, formed from the X and Y overflow bits together

The resolution flag is high for 800 counts per inch and low for 400. All outputs change together in the cycle in which a one-cycle completion pulse is raised. The serial timing and any position accumulation belong to other blocks.

Top module: `mps_poll_seq`

## Requirements
- R1: One sequence issues exactly three reads, to addresses BASE_ADDR, BASE_ADDR+1 and BASE_ADDR+2 (default 0x02, 0x03, 0x04), in that order.
- R2: Each read request on rd_req_o lasts one cycle. The next request is not issued until rd_ack_i has returned the data for the current one.
- R3: result_o[0] is 1 exactly when bit 7 of the status byte (motion) is 1.
- R4: result_o[1] is 1 exactly when bit 1 of the status byte (LED fault) is 1.
- R5: result_o[2] is 1 when bit 3 (X overflow) or bit 4 (Y overflow) of the status byte is 1, or both are.
- R6: hires_o is 1 (800 counts per inch) when bit 0 of the status byte is 1, and 0 (400 counts per inch) when it is 0.
- R7: When none of status bits 7, 4, 3, 1 is set, result_o is 0. Status bits 2, 5 and 6 have no effect on any output.
- R8: dx_o and dy_o carry the second and third bytes read, as 8-bit two's complement values. They, result_o and hires_o change only when the third read completes; they hold their values while a sequence runs and between sequences.
- R9: done_o is a one-cycle pulse in the first cycle after the third acknowledge, and the new outputs are valid in that same cycle.
- R10: A start_i pulse while a sequence is running is ignored. It adds no read request and no completion pulse.
- R11: After reset, done_o and rd_req_o are 0, result_o, dx_o and dy_o are 0, and hires_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to fetch a motion report |
| rd_req_o | output | 1 | One-cycle read request to the register master |
| rd_addr_o | output | ADDR_W | Register address for the current request |
| rd_ack_i | input | 1 | Read data valid from the register master |
| rd_data_i | input | DW | Byte returned by the register master |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 3 | {overflow, LED fault, motion} |
| hires_o | output | 1 | 1 = 800 counts per inch, 0 = 400 |
| dx_o | output | DW | Signed horizontal displacement |
| dy_o | output | DW | Signed vertical displacement |

## Verification
The assertions rely on three things about the register master: it answers each request with exactly one rd_ack_i pulse, that pulse comes no earlier than the cycle after the request, and it sends no acknowledge while no read is pending. The bench's master model waits for rd_req_o at a falling edge and then waits a chosen gap of at least one cycle. It then drives a single acknowledge with the byte for the address it saw, so it never acknowledges early or twice. The extra start pulses used for R10 fall only in cycles where a sequence is already running.

// File: rtl/mps_pkg.sv
package mps_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } seq_state_t;

   localparam int NUM_READS = 3;
   localparam int SLOT_W    = $clog2(NUM_READS);
   localparam int RES_W     = 3;
   localparam int RES_MOT   = 0;
   localparam int RES_FLT   = 1;
   localparam int RES_OVF   = 2;
endpackage

// File: rtl/mps_ctrl.sv
module mps_ctrl
   import mps_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int BASE_ADDR = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              ack_i,
   output logic              req_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [SLOT_W-1:0] slot_o,
   output logic              slot_we_o,
   output logic              commit_o,
   output logic              done_o
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_READS - 1);

   seq_state_t        state_q;
   logic [SLOT_W-1:0] slot_q;
   logic              done_q;
   logic              last_ack;

   assign last_ack = (state_q == ST_WAIT) && ack_i && (slot_q == LAST_SLOT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         slot_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_REQ;
                  slot_q  <= '0;
               end
            end
            ST_REQ: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (ack_i) begin
                  if (slot_q == LAST_SLOT) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     slot_q  <= slot_q + 1'b1;
                     state_q <= ST_REQ;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_o     = (state_q == ST_REQ);
   assign addr_o    = ADDR_W'(BASE_ADDR) + ADDR_W'(slot_q);
   assign slot_o    = slot_q;
   assign slot_we_o = (state_q == ST_WAIT) && ack_i;
   assign commit_o  = last_ack;
   assign done_o    = done_q;
endmodule

// File: rtl/mps_capture.sv
module mps_capture
   import mps_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  logic [DW-1:0]     data_i,
   input  logic              commit_i,
   output logic [DW-1:0]     word_o [NUM_READS]
);
   logic [DW-1:0] stage_q [NUM_READS-1];

   for (genvar g = 0; g < NUM_READS - 1; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[g] <= '0;
         else if (we_i && (slot_i == SLOT_W'(g)))
            stage_q[g] <= data_i;
      end
   end

   for (genvar k = 0; k < NUM_READS; k++) begin : g_commit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_o[k] <= '0;
         else if (commit_i) begin
            if (k == NUM_READS - 1)
               word_o[k] <= data_i;
            else
               word_o[k] <= stage_q[k];
         end
      end
   end
endmodule

// File: rtl/mps_status_dec.sv
module mps_status_dec
   import mps_pkg::*;
#(
   parameter int DW        = 8,
   parameter int MOT_BIT   = 7,
   parameter int FLT_BIT   = 1,
   parameter int OVX_BIT   = 3,
   parameter int OVY_BIT   = 4,
   parameter int HIRES_BIT = 0
) (
   input  logic [DW-1:0]    status_i,
   output logic [RES_W-1:0] result_o,
   output logic             hires_o
);
   always_comb begin
      result_o          = '0;
      result_o[RES_MOT] = status_i[MOT_BIT];
      result_o[RES_FLT] = status_i[FLT_BIT];
      result_o[RES_OVF] = status_i[OVX_BIT] | status_i[OVY_BIT];
   end

   assign hires_o = status_i[HIRES_BIT];
endmodule

// File: rtl/mps_poll_seq.sv
module mps_poll_seq
   import mps_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int DW        = 8,
   parameter int BASE_ADDR = 2,
   parameter int MOT_BIT   = 7,
   parameter int FLT_BIT   = 1,
   parameter int OVX_BIT   = 3,
   parameter int OVY_BIT   = 4,
   parameter int HIRES_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [DW-1:0]     rd_data_i,
   output logic              done_o,
   output logic [RES_W-1:0]  result_o,
   output logic              hires_o,
   output logic [DW-1:0]     dx_o,
   output logic [DW-1:0]     dy_o
);
   if (BASE_ADDR + NUM_READS > (1 << ADDR_W)) begin : g_bad_addr
      $error("address window does not fit in ADDR_W bits");
   end
   if (DW < 5) begin : g_bad_dw
      $error("DW too narrow for status fields");
   end
   if (MOT_BIT >= DW || FLT_BIT >= DW || OVX_BIT >= DW ||
       OVY_BIT >= DW || HIRES_BIT >= DW) begin : g_bad_bit
      $error("status bit position outside DW");
   end
   if (MOT_BIT == FLT_BIT || OVX_BIT == OVY_BIT) begin : g_dup_bit
      $error("status bit positions overlap");
   end

   logic [SLOT_W-1:0] slot;
   logic              slot_we;
   logic              commit;
   logic [DW-1:0]     words [NUM_READS];

   mps_ctrl #(
      .ADDR_W   (ADDR_W),
      .BASE_ADDR(BASE_ADDR)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .ack_i    (rd_ack_i),
      .req_o    (rd_req_o),
      .addr_o   (rd_addr_o),
      .slot_o   (slot),
      .slot_we_o(slot_we),
      .commit_o (commit),
      .done_o   (done_o)
   );

   mps_capture #(
      .DW(DW)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (slot_we),
      .slot_i  (slot),
      .data_i  (rd_data_i),
      .commit_i(commit),
      .word_o  (words)
   );

   mps_status_dec #(
      .DW       (DW),
      .MOT_BIT  (MOT_BIT),
      .FLT_BIT  (FLT_BIT),
      .OVX_BIT  (OVX_BIT),
      .OVY_BIT  (OVY_BIT),
      .HIRES_BIT(HIRES_BIT)
   ) u_dec (
      .status_i(words[0]),
      .result_o(result_o),
      .hires_o (hires_o)
   );

   assign dx_o = words[1];
   assign dy_o = words[2];
endmodule

// File: rtl/mps_poll_seq_chk.sv
module mps_poll_seq_chk #(
   parameter int ADDR_W    = 7,
   parameter int DW        = 8,
   parameter int BASE_ADDR = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_req_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic              done_o,
   input logic [2:0]        result_o,
   input logic              hires_o,
   input logic [DW-1:0]     dx_o,
   input logic [DW-1:0]     dy_o
);
   logic [2:0] req_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         req_cnt <= '0;
      else if (done_o)
         req_cnt <= '0;
      else if (rd_req_o)
         req_cnt <= req_cnt + 1'b1;
   end

   // R1: requests walk the address window in ascending order
   a_r1_addr_order: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |-> (rd_addr_o == ADDR_W'(BASE_ADDR) + ADDR_W'(req_cnt)));

   // R2: a request lasts one cycle
   a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o |=> !rd_req_o);

   // R10: completion follows exactly three requests
   a_r10_three_reads: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (req_cnt == 3'd3));

   // R9: completion is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: outputs change only together with the completion pulse
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(dx_o) && $stable(dy_o) &&
                   $stable(result_o) && $stable(hires_o)));
endmodule

bind mps_poll_seq mps_poll_seq_chk #(
   .ADDR_W   (ADDR_W),
   .DW       (DW),
   .BASE_ADDR(BASE_ADDR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_req_o (rd_req_o),
   .rd_addr_o(rd_addr_o),
   .done_o   (done_o),
   .result_o (result_o),
   .hires_o  (hires_o),
   .dx_o     (dx_o),
   .dy_o     (dy_o)
);

// File: tb/tb_mps_poll_seq.sv
`timescale 1ns/1ps
module tb_mps_poll_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       rd_req_o;
   logic [6:0] rd_addr_o;
   logic       rd_ack_i = 1'b0;
   logic [7:0] rd_data_i = '0;
   logic       done_o;
   logic [2:0] result_o;
   logic       hires_o;
   logic [7:0] dx_o;
   logic [7:0] dy_o;

   int checks = 0;
   int errors = 0;
   logic [7:0] m_stat, m_dx, m_dy;
   logic [6:0] seen_addr [3];
   int         req_seen;

   always #2 clk = ~clk;

   mps_poll_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
      .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
      .done_o(done_o), .result_o(result_o), .hires_o(hires_o),
      .dx_o(dx_o), .dy_o(dy_o)
   );

   // {status, dx, dy, result, hires}
   localparam logic [27:0] VEC [10] = '{
      {8'h00, 8'h00, 8'h00, 3'd0, 1'b0},
      {8'h80, 8'h05, 8'hFB, 3'd1, 1'b0},
      {8'h02, 8'h11, 8'h22, 3'd2, 1'b0},
      {8'h08, 8'h7F, 8'h80, 3'd4, 1'b0},
      {8'h10, 8'h80, 8'h7F, 3'd4, 1'b0},
      {8'h18, 8'h01, 8'hFF, 3'd4, 1'b0},
      {8'h01, 8'h33, 8'h44, 3'd0, 1'b1},
      {8'hFF, 8'hAA, 8'h55, 3'd7, 1'b1},
      {8'h64, 8'hC0, 8'h40, 3'd0, 1'b0},
      {8'h83, 8'hFE, 8'h02, 3'd3, 1'b1}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] model_rd(input logic [6:0] a);
      case (a)
         7'h02: return m_stat;
         7'h03: return m_dx;
         7'h04: return m_dy;
         default: return 8'hEE;
      endcase
   endfunction

   // master model: run one sequence, optional extra start while busy
   task automatic run_poll(input int gap, input bit extra_start,
                           input logic [7:0] old_dx);
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      req_seen = 0;
      for (int k = 0; k < 3; k++) begin
         while (!rd_req_o) @(negedge clk);
         seen_addr[k] = rd_addr_o;
         req_seen++;
         if (extra_start && k == 0) start_i = 1'b1;
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            start_i = 1'b0;
         end
         if (k == 2)
            chk("R8 dx held before last read", int'(dx_o), int'(old_dx));
         if (extra_start && k == 1) start_i = 1'b1;
         rd_ack_i  = 1'b1;
         rd_data_i = model_rd(rd_addr_o);
         @(negedge clk);
         rd_ack_i  = 1'b0;
         start_i   = 1'b0;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] prev_dx;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 done", int'(done_o), 0);
      chk("R11 req", int'(rd_req_o), 0);
      chk("R11 result", int'(result_o), 0);
      chk("R11 hires", int'(hires_o), 0);
      chk("R11 dx", int'(dx_o), 0);
      chk("R11 dy", int'(dy_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      prev_dx = 8'h00;

      for (int v = 0; v < 10; v++) begin
         m_stat = VEC[v][27:20];
         m_dx   = VEC[v][19:12];
         m_dy   = VEC[v][11:4];
         run_poll(1 + (v % 3), 1'b0, prev_dx);
         // R9: outputs valid with the pulse
         chk("R9 done pulse", int'(done_o), 1);
         chk("R3 R4 R5 R7 result", int'(result_o), int'(VEC[v][3:1]));
         chk("R6 hires", int'(hires_o), int'(VEC[v][0]));
         chk("R8 dx", int'(dx_o), int'(m_dx));
         chk("R8 dy", int'(dy_o), int'(m_dy));
         chk("R1 addr0", int'(seen_addr[0]), 2);
         chk("R1 addr1", int'(seen_addr[1]), 3);
         chk("R1 addr2", int'(seen_addr[2]), 4);
         @(negedge clk);
         chk("R9 done one cycle", int'(done_o), 0);
         prev_dx = m_dx;
      end

      // R8: outputs hold between sequences when the source changes
      m_stat = 8'h00; m_dx = 8'h12; m_dy = 8'h34;
      repeat (5) @(negedge clk);
      chk("R8 idle hold dx", int'(dx_o), 8'hFE);
      chk("R8 idle hold result", int'(result_o), 3);

      // R10: extra starts during a running sequence
      m_stat = 8'h90; m_dx = 8'h9C; m_dy = 8'h64;
      run_poll(2, 1'b1, 8'hFE);
      chk("R10 request count", req_seen, 3);
      chk("R10 done", int'(done_o), 1);
      chk("R5 R3 result", int'(result_o), 5);
      chk("R8 negative dx", int'($signed(dx_o)), -100);
      begin
         int extra = 0;
         for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (rd_req_o || done_o) extra++;
         end
         chk("R10 no extra activity", extra, 0);
      end

      // R2: no second request before the acknowledge
      m_stat = 8'h00; m_dx = 8'h00; m_dy = 8'h00;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      begin
         int reqs = 0;
         for (int c = 0; c < 8; c++) begin
            if (rd_req_o) reqs++;
            @(negedge clk);
         end
         chk("R2 single request while unacknowledged", reqs, 1);
      end
      rd_ack_i = 1'b1; rd_data_i = 8'h00;
      @(negedge clk) rd_ack_i = 1'b0;
      chk("R2 next request after ack", int'(rd_req_o), 1);
      chk("R1 second address", int'(rd_addr_o), 3);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule